// File: doc/BRIEF.md
# Serial-in Latched Parallel-out Register

This block turns a serial bit stream into a parallel word. Bits are clocked into a chain of stages by one clock. A second, independent clock copies the whole chain at once into a holding word, and that word drives the parallel outputs. The holding word keeps its value while new bits are shifted in behind it, so the parallel outputs change only on a storage-clock edge.

The last stage of the chain is brought out as a cascade line. The cascade line of one instance feeds the serial input of the next, which gives wider words. An active-low clear empties the chain at once, without a clock, and leaves the holding word alone. An active-low output enable releases the parallel outputs to high impedance. A separate valid signal shows the same condition for targets that have no internal tri-states.

The holding word has no reset. It is undefined until the first storage-clock edge.

Top module: `serlatch_reg`

## Requirements
- R1: On each rising edge of `shift_clk` with `clr_n` high, stage 0 takes `ser_in` and each stage k takes the old value of stage k-1.
- R2: `cascade_out` equals the last stage (stage STAGES-1). After a shift edge it shows what stage STAGES-2 held before that edge.
- R3: On each rising edge of `store_clk`, all stages of the chain are copied in parallel into the holding word. Stage k goes to bit k of `par_out`.
- R4: While `clr_n` is low, every chain stage is 0 (so `cascade_out` is 0). This takes effect at once, with no clock edge.
- R5: A low `clr_n` leaves the holding word, and so the value on `par_out`, unchanged.
- R6: A `store_clk` edge while `clr_n` is low loads all zeros into the holding word.
- R7: When `shift_clk` and `store_clk` rise together, the holding word captures the chain contents from before that edge. It therefore lags the chain by one pulse.
- R8: While `oe_n` is low, `par_valid` is 1 and `par_out` drives the holding word.
- R9: While `oe_n` is high, `par_valid` is 0 and every bit of `par_out` is high impedance.
- R10: `oe_n` has no effect on the chain or on `cascade_out`. Bits shifted in while the outputs are released appear on `par_out` after a later store edge with `oe_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Rising edge advances the chain |
| store_clk | input | 1 | Rising edge copies the chain into the holding word |
| clr_n | input | 1 | Asynchronous clear of the chain, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| par_out | output | STAGES | Holding word, or high impedance |
| par_valid | output | 1 | 1 while `par_out` is driven |
| cascade_out | output | 1 | Last chain stage, always driven |

## Verification
The hardest case to reach is the interaction of the two clock domains: a clear arriving between edges while the holding word already carries data. The bench first loads a known word into the holding register. It then drops `clr_n` half-way between clock pulses and checks two things: `cascade_out` falls at once, and `par_out` keeps the old word. Only after that does it pulse `store_clk` under clear, to show that zeros get loaded. The one-pulse lag is reached by driving both clocks from one task on the same instant, with the holding word compared against a bench model of the chain taken before each edge.

// File: rtl/slr_pkg.sv
// Package: shared constants for the serial-in latched parallel-out register.
// Assumes: nothing; it holds only elaboration-time values.
package slr_pkg;
    // Default number of chain stages and holding-word bits.
    localparam int unsigned SLR_STAGES = 8;
endpackage

// File: rtl/slr_shift_chain.sv
// Module: slr_shift_chain
// A chain of STAGES flops clocked by shift_clk. Stage 0 takes ser_in and each
// later stage takes its predecessor. An asynchronous active-low clear forces
// every stage to 0.
// Assumes: clr_n may change at any time, not tied to shift_clk.
module slr_shift_chain #(
    parameter int unsigned STAGES = slr_pkg::SLR_STAGES
) (
    input  logic              shift_clk,
    input  logic              clr_n,
    input  logic              ser_in,
    output logic [STAGES-1:0] chain_q
);
    localparam int unsigned LAST = STAGES - 1;

    // One flop per stage, built by generate.
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_head
            // Purpose: stage 0 captures the serial input.
            always_ff @(posedge shift_clk or negedge clr_n) begin
                if (!clr_n) chain_q[gi] <= 1'b0;
                else        chain_q[gi] <= ser_in;
            end
        end else begin : g_body
            // Purpose: stage gi takes the old value of stage gi-1.
            always_ff @(posedge shift_clk or negedge clr_n) begin
                if (!clr_n) chain_q[gi] <= 1'b0;
                else        chain_q[gi] <= chain_q[gi-1];
            end
        end
    end

    // Checker flag: set once a shift edge has passed since the last clear.
    logic edge_seen;
    // Purpose: track whether the previous shift edge came after the last clear.
    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) edge_seen <= 1'b0;
        else        edge_seen <= 1'b1;
    end

    AST_SHIFT_HEAD: assert property (@(posedge shift_clk) disable iff (!clr_n)
        edge_seen |-> (chain_q[0] == $past(ser_in))); // R1
    AST_SHIFT_BODY: assert property (@(posedge shift_clk) disable iff (!clr_n)
        edge_seen |-> (chain_q[LAST:1] == $past(chain_q[LAST-1:0]))); // R1
    AST_CLEAR_EMPTY: assert property (@(posedge shift_clk) disable iff (clr_n)
        (chain_q == '0)); // R4
endmodule

// File: rtl/slr_hold_bank.sv
// Module: slr_hold_bank
// The holding word. On each rising store_clk it copies the whole chain in
// parallel. It has no reset: its content is undefined until the first edge.
// Assumes: chain_q is stable around the store_clk edge, or changes on the same
// instant (tied clocks), in which case the pre-edge value is taken.
module slr_hold_bank #(
    parameter int unsigned STAGES = slr_pkg::SLR_STAGES
) (
    input  logic              store_clk,
    input  logic              clr_n,
    input  logic [STAGES-1:0] chain_q,
    output logic [STAGES-1:0] hold_q
);
    // Purpose: copy the chain into the holding word, with no reset.
    always_ff @(posedge store_clk) begin
        hold_q <= chain_q;
    end

    // Checker flag: a store edge has passed since the last clear.
    logic store_seen;
    // Purpose: mark that hold_q has been loaded at least once.
    always_ff @(posedge store_clk or negedge clr_n) begin
        if (!clr_n) store_seen <= 1'b0;
        else        store_seen <= 1'b1;
    end

    AST_STORE_COPY: assert property (@(posedge store_clk) disable iff (!clr_n)
        store_seen |-> (hold_q == $past(chain_q))); // R3
endmodule

// File: rtl/slr_out_stage.sv
// Module: slr_out_stage
// Turns the active-low enable into a drive flag and passes the holding word on.
// The top level applies the tri-state using this flag.
// Assumes: oe_n is a level and needs no clock.
module slr_out_stage #(
    parameter int unsigned STAGES = slr_pkg::SLR_STAGES
) (
    input  logic              oe_n,
    input  logic [STAGES-1:0] hold_q,
    output logic              drive_en,
    output logic [STAGES-1:0] drive_word
);
    // Purpose: derive the drive flag and the word to drive.
    always_comb begin
        drive_en   = ~oe_n;
        drive_word = hold_q;
    end
endmodule

// File: rtl/serlatch_reg.sv
// Module: serlatch_reg (top)
// A serial-in chain, a parallel holding word on its own clock, tri-state
// parallel outputs and an always-driven cascade output.
// Assumes: shift_clk and store_clk are independent rising-edge domains. They
// may be tied together. clr_n is asynchronous and clears only the chain.
module serlatch_reg #(
    parameter int unsigned STAGES = slr_pkg::SLR_STAGES
) (
    input  logic              shift_clk,
    input  logic              store_clk,
    input  logic              clr_n,
    input  logic              oe_n,
    input  logic              ser_in,
    output logic [STAGES-1:0] par_out,
    output logic              par_valid,
    output logic              cascade_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] hold_q;
    logic [STAGES-1:0] drive_word;
    logic              drive_en;

    slr_shift_chain #(.STAGES(STAGES)) u_chain (
        .shift_clk (shift_clk),
        .clr_n     (clr_n),
        .ser_in    (ser_in),
        .chain_q   (chain_q)
    );

    slr_hold_bank #(.STAGES(STAGES)) u_hold (
        .store_clk (store_clk),
        .clr_n     (clr_n),
        .chain_q   (chain_q),
        .hold_q    (hold_q)
    );

    slr_out_stage #(.STAGES(STAGES)) u_out (
        .oe_n       (oe_n),
        .hold_q     (hold_q),
        .drive_en   (drive_en),
        .drive_word (drive_word)
    );

    // Purpose: tri-state parallel outputs, a valid flag, and the cascade tap.
    assign par_out     = drive_en ? drive_word : {STAGES{1'bz}};
    assign par_valid   = drive_en;
    assign cascade_out = chain_q[LAST];

    // Checker flag: a shift edge has passed since the last clear.
    logic casc_seen;
    // Purpose: qualify the cascade check on a known previous chain.
    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) casc_seen <= 1'b0;
        else        casc_seen <= 1'b1;
    end

    AST_CASCADE_LAG: assert property (@(posedge shift_clk) disable iff (!clr_n)
        casc_seen |-> (cascade_out == $past(chain_q[LAST-1]))); // R2
    AST_RELEASE_INVALID: assert property (@(posedge store_clk) disable iff (!clr_n)
        oe_n |-> !par_valid); // R9
endmodule

// File: tb/serlatch_reg_tb.sv
// Bench for serlatch_reg: two instances chained through the cascade line.
// A 16-bit model of the combined chain gives every expected value.
module serlatch_reg_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz timebase

    logic sh_clk = 1'b0, st_clk = 1'b0, clr_n = 1'b0, oe_n = 1'b0, din = 1'b0;
    wire [W-1:0] par_a, par_b;
    wire         val_a, val_b, casc_a, casc_b;

    serlatch_reg #(.STAGES(W)) u_dut (
        .shift_clk(sh_clk), .store_clk(st_clk), .clr_n(clr_n), .oe_n(oe_n),
        .ser_in(din), .par_out(par_a), .par_valid(val_a), .cascade_out(casc_a));
    serlatch_reg #(.STAGES(W)) u_nxt (
        .shift_clk(sh_clk), .store_clk(st_clk), .clr_n(clr_n), .oe_n(oe_n),
        .ser_in(casc_a), .par_out(par_b), .par_valid(val_b), .cascade_out(casc_b));

    int n_chk = 0, n_err = 0;
    logic [15:0] model = '0;   // combined chain, bit p = chain position p
    logic [15:0] held  = '0;   // expected holding words {b, a}

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_one(input logic b);
        @(negedge clk); din = b;
        @(negedge clk); sh_clk = 1'b1;
        @(negedge clk); sh_clk = 1'b0;
        if (clr_n) model = {model[14:0], b};
    endtask

    task automatic store_one();
        @(negedge clk); st_clk = 1'b1;
        @(negedge clk); st_clk = 1'b0;
        held = clr_n ? model : 16'h0;
    endtask

    task automatic both_one(input logic b);
        @(negedge clk); din = b;
        @(negedge clk); sh_clk = 1'b1; st_clk = 1'b1;
        @(negedge clk); sh_clk = 1'b0; st_clk = 1'b0;
        held  = model;
        model = {model[14:0], b};
    endtask

    task automatic check_words(input string req);
        check({par_b, par_a} === held, req, {16'h0, par_b, par_a}, {16'h0, held});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] pat;
        repeat (3) @(negedge clk);
        // R4: reset state of the chain.
        check(casc_a == 1'b0 && casc_b == 1'b0, "R4", {30'h0, casc_b, casc_a}, 32'h0);
        // R6: store edge under clear loads zeros.
        store_one();
        #1 check_words("R6");
        @(negedge clk); clr_n = 1'b1;

        // R1 R2 R3 R8: sweep of patterns, MSB first through the chain.
        for (int p = 0; p < 40; p++) begin
            pat = (p < 16) ? (16'h1 << p) : (p < 32) ? ~(16'h1 << (p - 16))
                : 16'(p * 16'h9E37 + 16'h1234);
            for (int s = 0; s < 16; s++) begin
                shift_one(pat[15 - s]);
                #1 check(casc_a == model[7] && casc_b == model[15], "R2 R1",
                         {30'h0, casc_b, casc_a}, {30'h0, model[15], model[7]});
            end
            store_one();
            #1 check_words("R3 R1");
            check(held == pat, "R1", {16'h0, held}, {16'h0, pat});
            check(val_a && val_b, "R8", {30'h0, val_b, val_a}, 32'h3);
        end

        // R9 R10: release outputs, shift a new word, chain unaffected.
        @(negedge clk); oe_n = 1'b1;
        #1 check(!val_a && !val_b, "R9", {30'h0, val_b, val_a}, 32'h0);
        for (int s = 0; s < 16; s++) shift_one(s[0] ^ s[2]);
        #1 check(casc_a == model[7] && casc_b == model[15], "R10",
                 {30'h0, casc_b, casc_a}, {30'h0, model[15], model[7]});
        store_one();
        #1 check(!val_a && !val_b, "R9", {30'h0, val_b, val_a}, 32'h0);
        @(negedge clk); oe_n = 1'b0;
        #1 check_words("R10");

        // R4 R5: clear between edges; outputs keep the held word.
        #1 clr_n = 1'b0;
        #0.5 check(casc_a == 1'b0 && casc_b == 1'b0, "R4", {30'h0, casc_b, casc_a}, 32'h0);
        model = '0;
        check_words("R5");
        shift_one(1'b1);
        #1 check(casc_a == 1'b0, "R4", {31'h0, casc_a}, 32'h0);
        check_words("R5");
        store_one();
        #1 check_words("R6");
        @(negedge clk); clr_n = 1'b1;

        // R7: tied clocks, holding word lags the chain by one pulse.
        for (int s = 0; s < 20; s++) begin
            both_one(s[0] | s[3]);
            #1 check_words("R7");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule